// File: doc/BRIEF.md
# Looping Sequencer Program Engine

This block runs a small program that decides the order in which clock pattern blocks are played. It reads one instruction word at a time from an external program memory. It decodes the word and acts on it. Instructions may run a pattern block, open and close counted or endless loops, call and return from subroutines, or stop the program. When a run instruction has a non-zero repeat count, the engine passes a pattern offset and that count to a separate pattern player. It then waits for the player's done pulse before fetching the next instruction.

A host pulses `start` to run the program from address 0. `busy` stays high until the program stops. The program stops on a stop instruction, on an accepted abort, or on an error. Loop state and return addresses are kept in two hardware stacks, each eight entries deep by default. A stack overflow, a stack underflow or an undefined opcode raises a sticky error and halts the program.

Top module: `seq_engine`

## Requirements
- R1: An instruction word holds its opcode in bits [30:28], a 16-bit count in bits [26:11] and an 11-bit address in bits [10:0]. Opcode 001 (run) with a non-zero count raises `pat_req` with `pat_offset` set to bits [10:0] and `pat_count` set to bits [26:11]. These outputs hold steady until `pat_done`, and then the next instruction executes.
- R2: A run instruction with count 0 issues no pattern request and moves on to the next instruction.
- R3: Opcode 010 (loop, count N) opens a loop that is closed by opcode 011 (loop end). The body runs N times, and it runs once when N is 0 or 1.
- R4: Loops nest. An inner loop runs its full count on every pass of the outer loop.
- R5: Opcode 101 (call) jumps to the address in bits [10:0]. Opcode 110 (return) resumes at the instruction after that call.
- R6: Opcode 000 (stop) ends the program: `busy` falls, `err` stays 0, and no pattern request or memory read is issued while idle.
- R7: Opcode 100 opens an endless loop, closed by loop end, that repeats until `abort`. An abort takes effect only after the running pattern reports done, including when both arrive in the same cycle. It then stops the program without error.
- R8: A ninth nested push onto either stack, or a loop end or return on an empty stack, sets `err` and halts. Eight nested loops run normally.
- R9: Opcode 111 sets `err` and halts the program.
- R10: `err` stays set until the next accepted `start`, which clears it. A `start` while `busy` is ignored.
- R11: After reset, `busy`, `err`, `pat_req` and `pm_rd` are 0. An `abort` while idle has no effect on the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the program at address 0 (used only when idle) |
| abort | input | 1 | Request a stop at the next pattern boundary |
| busy | output | 1 | Program running |
| err | output | 1 | Sticky error flag |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 11 | Program memory read address |
| pm_data | input | 32 | Program memory data, valid one cycle after `pm_rd` |
| pat_req | output | 1 | Pattern run request to the player |
| pat_offset | output | 11 | Pattern memory offset of the requested block |
| pat_count | output | 16 | Repeat count for the requested block |
| pat_done | input | 1 | One-cycle pulse from the player when the request is finished |

## Verification
Two functions can fall in the same cycle: the player's completion of a pattern and an abort request. The bench provokes this by having its player model raise `abort` in exactly the cycle in which it pulses `pat_done` for the third pass of an endless loop. The run is judged correct when the scoreboard has received exactly three requests, `busy` has dropped and `err` is clear. A second case raises `abort` in the middle of a pattern and must likewise see that pattern finish with nothing issued after it.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEQ_AW  = 11;
  localparam int SEQ_CW  = 16;
  localparam int SEQ_IW  = 32;
  localparam int OP_HI   = 30;
  localparam int OP_LO   = 28;
  localparam int CNT_HI  = 26;
  localparam int CNT_LO  = 11;
  localparam int ADR_HI  = 10;
  localparam int ADR_LO  = 0;

  typedef enum logic [2:0] {
    OP_STOP = 3'b000,
    OP_RUN  = 3'b001,
    OP_LOOP = 3'b010,
    OP_LEND = 3'b011,
    OP_LINF = 3'b100,
    OP_CALL = 3'b101,
    OP_RET  = 3'b110,
    OP_BAD  = 3'b111
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [SEQ_CW-1:0] cnt;
    logic [SEQ_AW-1:0] adr;
  } instr_t;

  typedef struct packed {
    logic              endless;
    logic [SEQ_CW-1:0] remain;
    logic [SEQ_AW-1:0] body;
  } loop_ent_t;

  localparam int LOOP_EW = $bits(loop_ent_t);

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_EXEC  = 2'd2,
    S_PAT   = 2'd3
  } st_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [SEQ_IW-1:0] word,
  output instr_t            ins
);
  logic unused_bits;
  assign unused_bits = ^{word[SEQ_IW-1], word[OP_LO-1]};

  always_comb begin
    ins.op  = op_e'(word[OP_HI:OP_LO]);
    ins.cnt = word[CNT_HI:CNT_LO];
    ins.adr = word[ADR_HI:ADR_LO];
  end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int W     = 11,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int PW  = $clog2(DEPTH + 1);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]  sp_q, sp_n;
  logic [W-1:0]   mem [DEPTH];
  logic [IXW-1:0] wr_ix, tp_ix;

  assign wr_ix = IXW'(sp_q);
  assign tp_ix = IXW'(sp_q - 1'b1);
  assign full  = (sp_q == PW'(DEPTH));
  assign empty = (sp_q == '0);
  assign top   = mem[tp_ix];

  always_comb begin
    sp_n = sp_q;
    if (clr)       sp_n = '0;
    else if (push) sp_n = sp_q + 1'b1;
    else if (pop)  sp_n = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  always_ff @(posedge clk) begin
    if (push)     mem[wr_ix] <= din;
    else if (upd) mem[tp_ix] <= din;
  end

  AST_STK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full)); // R8
  AST_STK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !((pop || upd) && empty)); // R8
  AST_STK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop, upd})); // R3
endmodule

// File: rtl/seq_engine.sv
module seq_engine
  import seq_pkg::*;
#(
  parameter int LOOP_DEPTH = 8,
  parameter int CALL_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  output logic              busy,
  output logic              err,
  output logic              pm_rd,
  output logic [SEQ_AW-1:0] pm_addr,
  input  logic [SEQ_IW-1:0] pm_data,
  output logic              pat_req,
  output logic [SEQ_AW-1:0] pat_offset,
  output logic [SEQ_CW-1:0] pat_count,
  input  logic              pat_done
);
  st_e               st_q, st_n;
  logic [SEQ_AW-1:0] pc_q, pc_n;
  logic              err_q, err_n;
  logic              abt_q, abt_n;
  logic [SEQ_AW-1:0] off_q, off_n;
  logic [SEQ_CW-1:0] cnt_q, cnt_n;

  instr_t            ins;
  logic [SEQ_AW-1:0] pc_inc;

  logic              stk_clr;
  logic              l_push, l_pop, l_upd, l_full, l_empty;
  loop_ent_t         l_din, l_top;
  logic [LOOP_EW-1:0] l_top_raw;
  logic              r_push, r_pop, r_full, r_empty;
  logic [SEQ_AW-1:0] r_top;

  seq_decode u_dec (
    .word (pm_data),
    .ins  (ins)
  );

  seq_stack #(.W(LOOP_EW), .DEPTH(LOOP_DEPTH)) u_loop_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stk_clr),
    .push  (l_push),
    .pop   (l_pop),
    .upd   (l_upd),
    .din   (l_din),
    .top   (l_top_raw),
    .full  (l_full),
    .empty (l_empty)
  );
  assign l_top = loop_ent_t'(l_top_raw);

  seq_stack #(.W(SEQ_AW), .DEPTH(CALL_DEPTH)) u_call_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stk_clr),
    .push  (r_push),
    .pop   (r_pop),
    .upd   (1'b0),
    .din   (pc_inc),
    .top   (r_top),
    .full  (r_full),
    .empty (r_empty)
  );

  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    st_n    = st_q;
    pc_n    = pc_q;
    err_n   = err_q;
    abt_n   = abt_q;
    off_n   = off_q;
    cnt_n   = cnt_q;
    stk_clr = 1'b0;
    l_push  = 1'b0;
    l_pop   = 1'b0;
    l_upd   = 1'b0;
    l_din   = '0;
    r_push  = 1'b0;
    r_pop   = 1'b0;

    if (st_q != S_IDLE && abort) abt_n = 1'b1;

    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_n    = S_FETCH;
          pc_n    = '0;
          err_n   = 1'b0;
          abt_n   = 1'b0;
          stk_clr = 1'b1;
        end
      end
      S_FETCH: begin
        st_n = abt_q ? S_IDLE : S_EXEC;
      end
      S_EXEC: begin
        st_n = S_FETCH;
        case (ins.op)
          OP_RUN: begin
            if (ins.cnt != '0) begin
              off_n = ins.adr;
              cnt_n = ins.cnt;
              st_n  = S_PAT;
            end else begin
              pc_n = pc_inc;
            end
          end
          OP_LOOP, OP_LINF: begin
            if (l_full) begin
              err_n = 1'b1;
              st_n  = S_IDLE;
            end else begin
              l_push        = 1'b1;
              l_din.endless = (ins.op == OP_LINF);
              l_din.remain  = ins.cnt;
              l_din.body    = pc_inc;
              pc_n          = pc_inc;
            end
          end
          OP_LEND: begin
            if (l_empty) begin
              err_n = 1'b1;
              st_n  = S_IDLE;
            end else if (l_top.endless) begin
              pc_n = l_top.body;
            end else if (l_top.remain > SEQ_CW'(1)) begin
              l_upd        = 1'b1;
              l_din        = l_top;
              l_din.remain = l_top.remain - 1'b1;
              pc_n         = l_top.body;
            end else begin
              l_pop = 1'b1;
              pc_n  = pc_inc;
            end
          end
          OP_CALL: begin
            if (r_full) begin
              err_n = 1'b1;
              st_n  = S_IDLE;
            end else begin
              r_push = 1'b1;
              pc_n   = ins.adr;
            end
          end
          OP_RET: begin
            if (r_empty) begin
              err_n = 1'b1;
              st_n  = S_IDLE;
            end else begin
              r_pop = 1'b1;
              pc_n  = r_top;
            end
          end
          OP_STOP: st_n = S_IDLE;
          default: begin
            err_n = 1'b1;
            st_n  = S_IDLE;
          end
        endcase
      end
      S_PAT: begin
        if (pat_done) begin
          pc_n = pc_inc;
          st_n = S_FETCH;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      pc_q  <= '0;
      err_q <= 1'b0;
      abt_q <= 1'b0;
      off_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      pc_q  <= pc_n;
      err_q <= err_n;
      abt_q <= abt_n;
      off_q <= off_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign err        = err_q;
  assign pm_rd      = (st_q == S_FETCH) && !abt_q;
  assign pm_addr    = pc_q;
  assign pat_req    = (st_q == S_PAT);
  assign pat_offset = off_q;
  assign pat_count  = cnt_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pat_req && !pat_done |=> pat_req && $stable(pat_offset) && $stable(pat_count)); // R1
  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pat_req |-> pat_count != '0); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pat_req && !pm_rd); // R6
  AST_ABORT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    pat_req && !pat_done && abort |=> pat_req); // R7
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(start && !busy) |=> err); // R10
endmodule

// File: tb/sim_seq_engine.sv
module sim_seq_engine;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        abort_t, abort_pl, abort;
  logic        busy, err, pm_rd, pat_req, pat_done;
  logic [10:0] pm_addr, pat_offset;
  logic [31:0] pm_data;
  logic [15:0] pat_count;

  int tests, fails;
  bit finished;

  logic [31:0] mem [0:63];
  logic [26:0] exp_q [$];

  int pstate, dly, done_cnt, abort_at_done;

  assign abort = abort_t | abort_pl;

  seq_engine u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (abort),
    .busy       (busy),
    .err        (err),
    .pm_rd      (pm_rd),
    .pm_addr    (pm_addr),
    .pm_data    (pm_data),
    .pat_req    (pat_req),
    .pat_offset (pat_offset),
    .pat_count  (pat_count),
    .pat_done   (pat_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (pm_rd) pm_data <= mem[pm_addr[5:0]];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // player model and scoreboard monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      pstate   = 0;
      pat_done <= 1'b0;
      abort_pl <= 1'b0;
      done_cnt = 0;
    end else begin
      case (pstate)
        0: begin
          if (!busy) done_cnt = 0;
          if (pat_req) begin
            if (exp_q.size() == 0) begin
              chk(0, "R1 unexpected pattern request", {pat_offset, pat_count}, 0);
            end else begin
              logic [26:0] e;
              e = exp_q.pop_front();
              chk({pat_offset, pat_count} == e, "R1 pattern offset/count",
                  {pat_offset, pat_count}, e);
            end
            dly    = 2;
            pstate = 1;
          end
        end
        1: begin
          if (dly == 0) begin
            pat_done <= 1'b1;
            done_cnt++;
            if (abort_at_done != 0 && done_cnt == abort_at_done) abort_pl <= 1'b1;
            pstate = 2;
          end else dly--;
        end
        default: begin
          pat_done <= 1'b0;
          abort_pl <= 1'b0;
          pstate   = 0;
        end
      endcase
    end
  end

  function automatic logic [31:0] ins(input logic [2:0] op, input int cnt, input int adr);
    return {1'b0, op, 1'b0, 16'(cnt), 11'(adr)};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic expect_pat(input int off, input int cnt);
    exp_q.push_back({11'(off), 16'(cnt)});
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle(input bit exp_err, input string req);
    int n;
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(!busy, {req, " busy cleared"}, busy, 0);
    chk(exp_q.size() == 0, {req, " all expected patterns issued"}, exp_q.size(), 0);
    chk(err == exp_err, {req, " error flag"}, err, exp_err);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; finished = 0;
    start = 0; abort_t = 0; abort_at_done = 0;
    rst_n = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !err && !pat_req && !pm_rd, "R11 reset outputs",
        {busy, err, pat_req, pm_rd}, 0);

    // R11 abort while idle has no effect; R1 R2 R6 basic run
    @(negedge clk) abort_t = 1;
    @(negedge clk) abort_t = 0;
    clear_mem();
    mem[0] = ins(3'b001, 3, 10);
    mem[1] = ins(3'b001, 0, 11);
    mem[2] = ins(3'b001, 65535, 2047);
    mem[3] = ins(3'b000, 0, 0);
    mem[4] = ins(3'b001, 1, 12);
    expect_pat(10, 3); expect_pat(2047, 65535);
    pulse_start();
    wait_idle(0, "R1 R2 R6 R11 run/skip/stop");

    // R3 counted loops, N=3 and N=0
    clear_mem();
    mem[0] = ins(3'b010, 3, 0);
    mem[1] = ins(3'b001, 1, 20);
    mem[2] = ins(3'b011, 0, 0);
    mem[3] = ins(3'b010, 0, 0);
    mem[4] = ins(3'b001, 1, 21);
    mem[5] = ins(3'b011, 0, 0);
    mem[6] = ins(3'b000, 0, 0);
    for (int i = 0; i < 3; i++) expect_pat(20, 1);
    expect_pat(21, 1);
    pulse_start();
    wait_idle(0, "R3 counted loop");

    // R4 nested loops
    clear_mem();
    mem[0] = ins(3'b010, 2, 0);
    mem[1] = ins(3'b001, 1, 30);
    mem[2] = ins(3'b010, 3, 0);
    mem[3] = ins(3'b001, 2, 31);
    mem[4] = ins(3'b011, 0, 0);
    mem[5] = ins(3'b011, 0, 0);
    mem[6] = ins(3'b000, 0, 0);
    for (int i = 0; i < 2; i++) begin
      expect_pat(30, 1);
      for (int j = 0; j < 3; j++) expect_pat(31, 2);
    end
    pulse_start();
    wait_idle(0, "R4 nested loops");

    // R5 call and return
    clear_mem();
    mem[0]  = ins(3'b101, 0, 10);
    mem[1]  = ins(3'b001, 1, 40);
    mem[2]  = ins(3'b101, 0, 10);
    mem[3]  = ins(3'b000, 0, 0);
    mem[10] = ins(3'b001, 4, 41);
    mem[11] = ins(3'b110, 0, 0);
    expect_pat(41, 4); expect_pat(40, 1); expect_pat(41, 4);
    pulse_start();
    wait_idle(0, "R5 call/return");

    // R7 endless loop, abort coinciding with third done
    clear_mem();
    mem[0] = ins(3'b100, 0, 0);
    mem[1] = ins(3'b001, 2, 60);
    mem[2] = ins(3'b011, 0, 0);
    mem[3] = ins(3'b001, 1, 61);
    for (int i = 0; i < 3; i++) expect_pat(60, 2);
    abort_at_done = 3;
    pulse_start();
    wait_idle(0, "R7 abort with done");
    abort_at_done = 0;

    // R7 abort mid-pattern waits for done
    expect_pat(60, 2);
    pulse_start();
    while (!pat_req) @(negedge clk);
    abort_t = 1;
    @(negedge clk) abort_t = 0;
    chk(busy, "R7 still busy while pattern runs", busy, 1);
    wait_idle(0, "R7 abort mid pattern");

    // R8 eight nested loops are fine
    clear_mem();
    for (int i = 0; i < 8; i++) mem[i] = ins(3'b010, 0, 0);
    mem[8] = ins(3'b001, 1, 70);
    for (int i = 9; i < 17; i++) mem[i] = ins(3'b011, 0, 0);
    mem[17] = ins(3'b000, 0, 0);
    expect_pat(70, 1);
    pulse_start();
    wait_idle(0, "R8 eight-deep loops");

    // R8 loop stack overflow
    clear_mem();
    for (int i = 0; i < 9; i++) mem[i] = ins(3'b010, 0, 0);
    mem[9] = ins(3'b001, 1, 71);
    pulse_start();
    wait_idle(1, "R8 loop overflow");

    // R10 error sticky while idle
    repeat (5) @(negedge clk);
    chk(err, "R10 error stays set", err, 1);

    // R10 start clears error
    clear_mem();
    pulse_start();
    wait_idle(0, "R10 start clears error");

    // R8 return on empty stack
    clear_mem();
    mem[0] = ins(3'b001, 1, 72);
    mem[1] = ins(3'b110, 0, 0);
    mem[2] = ins(3'b001, 1, 73);
    expect_pat(72, 1);
    pulse_start();
    wait_idle(1, "R8 return underflow");

    // R8 loop end on empty stack
    clear_mem();
    mem[0] = ins(3'b011, 0, 0);
    mem[1] = ins(3'b001, 1, 74);
    pulse_start();
    wait_idle(1, "R8 loop end underflow");

    // R8 call stack overflow (self-call)
    clear_mem();
    mem[0] = ins(3'b101, 0, 0);
    pulse_start();
    wait_idle(1, "R8 call overflow");

    // R9 undefined opcode
    clear_mem();
    mem[0] = ins(3'b001, 1, 75);
    mem[1] = ins(3'b111, 0, 0);
    mem[2] = ins(3'b001, 1, 76);
    expect_pat(75, 1);
    pulse_start();
    wait_idle(1, "R9 undefined opcode");

    // R10 start while busy ignored
    clear_mem();
    mem[0] = ins(3'b001, 1, 80);
    mem[1] = ins(3'b001, 1, 81);
    mem[2] = ins(3'b000, 0, 0);
    expect_pat(80, 1); expect_pat(81, 1);
    pulse_start();
    while (!pat_req) @(negedge clk);
    start = 1;
    @(negedge clk) start = 0;
    wait_idle(0, "R10 start while busy");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule